// File: doc/BRIEF.md
# Retriggerable Pulse Generator

This block is a clocked one-shot. It raises an output pulse whose length is a number of clock cycles when a trigger condition newly becomes true. Three inputs control it: an active-low trigger, an active-high trigger and an active-low clear. Each input is resynchronized to the block clock and then edge-detected.

A pulse starts in three cases. The first is when the high trigger rises while the low trigger is held low. The second is when the low trigger falls while the high trigger is held high. The third is when the clear is released while both triggers already enable firing.

A new trigger during a pulse reloads the length, so the pulse stretches. Asserting the clear cuts a running pulse short and blocks every trigger while the clear is held. The outputs are a true pulse and its complement.

Top module: `pulse_oneshot`

## Requirements
- R1: While `rst_n` is low and after it is released, `pulse_o` is 0 and `pulse_n_o` is 1 until a trigger fires.
- R2: A rising edge on `trig_hi_i` while `trig_lo_n_i` is low and `clr_n_i` is high starts a pulse.
- R3: A falling edge on `trig_lo_n_i` while `trig_hi_i` is high and `clr_n_i` is high starts a pulse. A rising edge on `trig_lo_n_i` starts nothing.
- R4: A rising edge on `clr_n_i` while `trig_lo_n_i` is low and `trig_hi_i` is high starts a pulse.
- R5: When `clr_n_i` goes low during a pulse, `pulse_o` drops at the third rising clock edge after the change, even if the programmed length has not elapsed.
- R6: `pulse_o` rises at the third rising clock edge after a trigger edge reaches the inputs. It then stays high for exactly `pulse_len_i` clock cycles.
- R7: A trigger during a running pulse reloads the length. `pulse_o` then stays high until `pulse_len_i` cycles after the pulse-start cycle of the last trigger.
- R8: Firing is edge-based. Holding a trigger condition steady yields only one pulse, and `pulse_o` never rises without a trigger.
- R9: While the synchronized `clr_n_i` is low, no trigger has any effect and `pulse_o` stays 0.
- R10: A trigger while `pulse_len_i` is 0 produces no pulse.
- R11: `pulse_n_o` is always the inverse of `pulse_o`.
- R12: `pulse_len_i` is sampled only in the cycle a pulse starts. Changing it during a pulse does not alter that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_n_i | input | 1 | Active-low trigger, asynchronous |
| trig_hi_i | input | 1 | Active-high trigger, asynchronous |
| clr_n_i | input | 1 | Active-low clear and release trigger, asynchronous |
| pulse_len_i | input | LEN_W | Pulse length in clock cycles |
| pulse_o | output | 1 | Pulse output |
| pulse_n_o | output | 1 | Complement of the pulse output |

## Verification
Each input change passes through two synchronizer flops and the counter register. A trigger or clear applied before rising edge n therefore shows on `pulse_o` just after edge n+2. Both starting and cutting short a pulse follow this timing. The bench drives inputs on falling edges and checks the output on the second falling edge after the change (still old value) and on the third (new value). A behavioural model feeds the inputs through a three-deep history queue, models the length with an integer countdown, and is compared with both outputs on every falling edge. Pulse widths are counted in falling edges, starting from the first high sample.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // One sample of the three control inputs, in their raw polarity
    typedef struct packed {
        logic lo_n;
        logic hi;
        logic clr_n;
    } trig_t;

    // Reset view: triggers inactive, clear asserted (safe)
    localparam trig_t TRIG_RESET = '{lo_n: 1'b1, hi: 1'b0, clr_n: 1'b0};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  trig_t raw_i,
    output trig_t sync_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        trig_t [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.chain[i] <= TRIG_RESET;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.chain[LAST];

endmodule

// File: rtl/oneshot_trigger.sv
module oneshot_trigger
    import oneshot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_t sync_i,
    output logic  fire_o
);

    typedef struct packed {
        trig_t prev;
    } edge_state_t;

    edge_state_t e_d, e_q;
    logic lo_fall, hi_rise, clr_rise, armed;

    always_comb begin
        e_d      = e_q;
        e_d.prev = sync_i;
        lo_fall  = e_q.prev.lo_n & ~sync_i.lo_n;
        hi_rise  = ~e_q.prev.hi & sync_i.hi;
        clr_rise = ~e_q.prev.clr_n & sync_i.clr_n;
        armed    = ~sync_i.lo_n & sync_i.hi & sync_i.clr_n;
        fire_o   = armed & (lo_fall | hi_rise | clr_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.prev <= TRIG_RESET;
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_n_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             pulse_o
);

    localparam logic [LEN_W-1:0] CNT_ZERO = '0;
    localparam logic [LEN_W-1:0] CNT_ONE  = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } timer_state_t;

    timer_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!clr_n_i) begin
            t_d.cnt = CNT_ZERO;
        end else if (fire_i) begin
            t_d.cnt = len_i;
        end else if (t_q.cnt != CNT_ZERO) begin
            t_d.cnt = t_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= CNT_ZERO;
        end else begin
            t_q <= t_d;
        end
    end

    assign pulse_o = (t_q.cnt != CNT_ZERO);

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
    import oneshot_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_lo_n_i,
    input  logic             trig_hi_i,
    input  logic             clr_n_i,
    input  logic [LEN_W-1:0] pulse_len_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    trig_t raw_in;
    trig_t trig_sync;
    logic  fire;
    logic  pulse;

    assign raw_in = '{lo_n: trig_lo_n_i, hi: trig_hi_i, clr_n: clr_n_i};

    oneshot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_in),
        .sync_o (trig_sync)
    );

    oneshot_trigger u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (trig_sync),
        .fire_o (fire)
    );

    oneshot_timer #(.LEN_W(LEN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .clr_n_i (trig_sync.clr_n),
        .len_i   (pulse_len_i),
        .pulse_o (pulse)
    );

    assign pulse_o   = pulse;
    assign pulse_n_o = ~pulse;

endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire,
    input logic             clr_sync,
    input logic [LEN_W-1:0] len,
    input logic             pulse
);

    AST_CLR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_sync |=> !pulse); // R9

    AST_CLR_CUTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !clr_sync) |=> !pulse); // R5

    AST_ZERO_LEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr_sync && len == '0) |=> !pulse); // R10

    AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr_sync && len != '0) |=> pulse); // R2

    AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(fire)); // R8

endmodule

bind pulse_oneshot oneshot_checker #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .clr_sync (trig_sync.clr_n),
    .len      (pulse_len_i),
    .pulse    (pulse_o)
);

// File: tb/pulse_oneshot_test.sv
`timescale 1ns/1ps
module pulse_oneshot_test;
    import oneshot_pkg::*;

    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lo_n = 1'b1;
    logic             hi = 1'b0;
    logic             clr_n = 1'b1;
    logic [LEN_W-1:0] len = 8'd5;
    logic             pulse_o, pulse_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pulse_oneshot #(.LEN_W(LEN_W), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_lo_n_i (lo_n),
        .trig_hi_i   (hi),
        .clr_n_i     (clr_n),
        .pulse_len_i (len),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference: input history plus an integer countdown
    trig_t hist[$];
    int    mcnt = 0;
    trig_t m_now, m_old;
    bit    en_now, en_old;

    initial begin
        for (int i = 0; i < 4; i++) hist.push_front(TRIG_RESET);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < 4; i++) hist.push_front(TRIG_RESET);
            mcnt = 0;
        end else begin
            hist.push_front('{lo_n: lo_n, hi: hi, clr_n: clr_n});
            m_now  = hist[2];
            m_old  = hist[3];
            en_now = !m_now.lo_n && m_now.hi && m_now.clr_n;
            en_old = !m_old.lo_n && m_old.hi && m_old.clr_n;
            if (!m_now.clr_n)           mcnt = 0;
            else if (en_now && !en_old) mcnt = int'(len);
            else if (mcnt > 0)          mcnt = mcnt - 1;
            while (hist.size() > 6) void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 model pulse", int'(pulse_o), int'(mcnt != 0));
            check("R11 complement", int'(pulse_n_o), int'(mcnt == 0));
        end
    end

    task automatic measure(output int w);
        w = 0;
        while (pulse_o === 1'b1 && w < 500) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(int n, string tag);
        int hi_seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse_o) hi_seen = 1;
        end
        check(tag, hi_seen, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        check("R1 pulse in reset", int'(pulse_o), 0);
        check("R1 complement in reset", int'(pulse_n_o), 1);
        rst_n = 1'b1;
        quiet(6, "R1 idle after reset");

        // R8: lo_n falls while hi low -> nothing
        lo_n = 1'b0;
        quiet(6, "R8 no fire without hi");

        // R2 with R6 latency and width
        hi = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 still low before latency", int'(pulse_o), 0);
        @(negedge clk);
        check("R2 pulse started", int'(pulse_o), 1);
        measure(w);
        check("R6 width", w, 5);
        quiet(10, "R8 held level no repeat");

        // R3: rising lo_n no fire; falling lo_n fires; R12 length held
        lo_n = 1'b1;
        quiet(6, "R3 rising lo_n ignored");
        lo_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 pulse started", int'(pulse_o), 1);
        len = 8'd2;
        measure(w);
        check("R12 width unaffected", w, 5);
        len = 8'd5;

        // R9: triggers ignored while clear low
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        hi = 1'b0;
        repeat (3) @(negedge clk);
        hi = 1'b1;
        repeat (3) @(negedge clk);
        lo_n = 1'b1;
        repeat (3) @(negedge clk);
        lo_n = 1'b0;
        quiet(6, "R9 blocked under clear");

        // R4: release of clear fires
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 pulse started", int'(pulse_o), 1);
        measure(w);
        check("R4 width", w, 5);

        // R5: clear cuts a long pulse
        len = 8'd20;
        hi = 1'b0;
        repeat (4) @(negedge clk);
        hi = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 long pulse started", int'(pulse_o), 1);
        repeat (3) @(negedge clk);
        clr_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 high before clear lands", int'(pulse_o), 1);
        @(negedge clk);
        check("R5 cut short", int'(pulse_o), 0);
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 release after cut", int'(pulse_o), 1);
        measure(w);
        check("R4 long width", w, 20);

        // R7: retrigger stretches
        len = 8'd6;
        hi = 1'b0;
        repeat (4) @(negedge clk);
        hi = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 first pulse started", int'(pulse_o), 1);
        repeat (2) @(negedge clk);
        hi = 1'b0;
        @(negedge clk);
        hi = 1'b1;
        measure(w);
        check("R7 stretched width", w, 9);

        // R10: zero length gives no pulse
        len = 8'd0;
        hi = 1'b0;
        repeat (4) @(negedge clk);
        hi = 1'b1;
        quiet(8, "R10 zero length");
        len = 8'd5;

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule